// File: doc/BRIEF.md
# I2C Target Controller with Merged Interrupt

This block is an I2C target (slave) controller that runs on a fast system clock and oversamples the open-drain SCL and SDA lines. After a start condition it collects a 7-bit address and a direction bit. If the address equals the programmed own address, it acknowledges. It then receives bytes into a receive holding register, or sends bytes from a transmit holding register. One shift register serves both directions.

Software reaches the block through a small register port with three locations. Location 0 is data: a read returns the received byte, and a write loads the byte to send. Location 1 is status. Location 2 holds the interrupt enables. If a byte completes while the previous one is still unread, the block holds SCL low until software reads. The enabled causes (transmit empty, receive ready, bus status) are ORed onto a single interrupt line.

Top module: `i2c_target_ctrl`

## Requirements
- R1: After reset, the status register (location 1) reads 0x02, meaning only transmit-empty is set. The enable register (location 2) reads 0, `irq` is 0, and neither pin is driven low.
- R2: A start condition (SDA falling while SCL is high) sets busy (status bit 4). A stop condition (SDA rising while SCL is high) clears busy and sets stop-seen (status bit 3). Writing 1 to status bit 3 clears stop-seen.
- R3: The block shifts in the address MSB first, followed by the direction bit. When the address matches `ownAddr`, SDA is pulled low during the ninth clock. On a mismatch SDA stays released for the rest of the transfer, and received bytes are neither acknowledged nor stored.
- R4: In write direction the block shifts data in MSB first. Each completed byte is copied into the data register, sets receive-ready (status bit 0), and is acknowledged during the ninth clock.
- R5: A read of location 0 returns the received byte and clears receive-ready.
- R6: If a byte completes while receive-ready is still 1, the block sets overflow (status bit 2) and holds SCL low from the following SCL fall. The held byte stays in the shift register. A read of location 0 returns the older byte, moves the held byte into the data register, and releases SCL. Writing 1 to status bit 2 clears overflow.
- R7: A write to location 0 clears transmit-empty (status bit 1). In read direction the held byte is loaded into the shift register at the end of the address acknowledge, and again after each byte the master acknowledges. Each load sets transmit-empty. The byte is driven MSB first, and status bit 6 reads 1 in read direction.
- R8: A master NAK (SDA high in the ninth clock) after a transmitted byte ends transmission. The block then releases SDA and ignores further clocks until a stop or start.
- R9: `irq` is the OR of transmit-empty AND enable bit 0, receive-ready AND enable bit 1, and stop-seen AND enable bit 2. With an enable at 0, its cause never reaches `irq`.
- R10: Selected (status bit 5) sets on an address match. It clears on the next stop or repeated start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rstN | input | 1 | Asynchronous active-low reset |
| ownAddr | input | 7 | Own 7-bit target address |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sclDriveLow | output | 1 | 1 pulls SCL low (clock stretch) |
| sdaDriveLow | output | 1 | 1 pulls SDA low (ACK or data 0) |
| regAddr | input | 2 | Register select: 0 data, 1 status, 2 enables |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (side effects on data read) |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, combinational from `regAddr` |
| irq | output | 1 | Merged interrupt request |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, 8-bit data and a 7-bit address, with the own address set to 0x5A. An SCL half period of 24 system clocks is much longer than the three-cycle edge-detection latency. That margin brings stretching into reach, because the bench master waits for the wired-AND SCL line to rise. It also lets the bench observe the direction turnaround between target-driven data and master-driven acknowledge on a shared SDA net.

// File: rtl/i2c_target_pkg.sv
package i2c_target_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_CHK,
    ST_IGNORE
  } ctrlState_t;

  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic loadTx;
    logic xferNow;
    logic xferHeld;
    logic setOverflow;
    logic setSelected;
    logic clrSelected;
    logic setBusy;
    logic clrBusy;
    logic setStop;
  } dpStrobe_t;

  localparam logic [1:0] REG_DATA   = 2'd0;
  localparam logic [1:0] REG_STATUS = 2'd1;
  localparam logic [1:0] REG_ENABLE = 2'd2;

  localparam int BIT_RXRDY = 0;
  localparam int BIT_TXEMP = 1;
  localparam int BIT_OVF   = 2;
  localparam int BIT_STOP  = 3;
  localparam int BIT_BUSY  = 4;
  localparam int BIT_SEL   = 5;
  localparam int BIT_RDIR  = 6;

  localparam int EN_TX  = 0;
  localparam int EN_RX  = 1;
  localparam int EN_BUS = 2;

endpackage

// File: rtl/i2c_target_datapath.sv
module i2c_target_datapath
  import i2c_target_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpStrobe_t         stb,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              sdaBit,
  output logic              addrMatch,
  output logic              rxFull,
  output logic              rxRead,
  output logic              readMode,
  output logic              txMsb,
  output logic              nextBit,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irq
);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic [DATA_W-1:0] shiftReg, rxData, txHold, statusVec;
  logic rxReady, txEmpty, overflow, stopSeen, busy, selected;
  logic [2:0] enables;
  logic txWrite, statusWr, enableWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS     = sclSync[SYNC_STAGES-1];
  assign sdaS     = sdaSync[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign sdaBit   = sdaS;

  assign addrMatch = (shiftReg[ADDR_W-1:0] == ownAddr);
  assign rxFull    = rxReady;
  assign txMsb     = txHold[DATA_W-1];
  assign nextBit   = shiftReg[DATA_W-2];

  assign rxRead   = regRdEn && (regAddr == REG_DATA);
  assign txWrite  = regWrEn && (regAddr == REG_DATA);
  assign statusWr = regWrEn && (regAddr == REG_STATUS);
  assign enableWr = regWrEn && (regAddr == REG_ENABLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxData   <= '0;
      txHold   <= '0;
      rxReady  <= 1'b0;
      txEmpty  <= 1'b1;
      overflow <= 1'b0;
      stopSeen <= 1'b0;
      busy     <= 1'b0;
      selected <= 1'b0;
      readMode <= 1'b0;
      enables  <= '0;
    end else begin
      if (stb.shiftIn)       shiftReg <= {shiftReg[DATA_W-2:0], sdaS};
      else if (stb.loadTx)   shiftReg <= txHold;
      else if (stb.shiftOut) shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};

      if (stb.xferNow)       rxData <= {shiftReg[DATA_W-2:0], sdaS};
      else if (stb.xferHeld) rxData <= shiftReg;

      if (stb.xferNow || stb.xferHeld) rxReady <= 1'b1;
      else if (rxRead)                 rxReady <= 1'b0;

      if (txWrite) txHold <= regWrData;

      if (txWrite)         txEmpty <= 1'b0;
      else if (stb.loadTx) txEmpty <= 1'b1;

      if (stb.setOverflow)                 overflow <= 1'b1;
      else if (statusWr && regWrData[BIT_OVF]) overflow <= 1'b0;

      if (stb.setStop)                      stopSeen <= 1'b1;
      else if (statusWr && regWrData[BIT_STOP]) stopSeen <= 1'b0;

      if (stb.setBusy)      busy <= 1'b1;
      else if (stb.clrBusy) busy <= 1'b0;

      if (stb.setSelected) begin
        selected <= 1'b1;
        readMode <= sdaS;
      end else if (stb.clrSelected) begin
        selected <= 1'b0;
        readMode <= 1'b0;
      end

      if (enableWr) enables <= regWrData[2:0];
    end
  end

  always_comb begin
    statusVec            = '0;
    statusVec[BIT_RXRDY] = rxReady;
    statusVec[BIT_TXEMP] = txEmpty;
    statusVec[BIT_OVF]   = overflow;
    statusVec[BIT_STOP]  = stopSeen;
    statusVec[BIT_BUSY]  = busy;
    statusVec[BIT_SEL]   = selected;
    statusVec[BIT_RDIR]  = readMode;
    unique case (regAddr)
      REG_DATA:   regRdData = rxData;
      REG_STATUS: regRdData = statusVec;
      REG_ENABLE: regRdData = {{(DATA_W-3){1'b0}}, enables};
      default:    regRdData = '0;
    endcase
  end

  assign irq = (txEmpty & enables[EN_TX]) | (rxReady & enables[EN_RX]) |
               (stopSeen & enables[EN_BUS]);

  AST_RX_READY_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxReady) |-> $past(stb.xferNow || stb.xferHeld)); // R4
  AST_TX_EMPTY_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadTx && !txWrite) |=> txEmpty); // R7
  AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !busy); // R2
  AST_SEL_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    selected |-> busy); // R10
  AST_IRQ_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (enables == 3'b000) |-> !irq); // R9

endmodule

// File: rtl/i2c_target_control.sv
module i2c_target_control
  import i2c_target_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startDet,
  input  logic      stopDet,
  input  logic      sdaBit,
  input  logic      addrMatch,
  input  logic      rxFull,
  input  logic      rxRead,
  input  logic      readMode,
  input  logic      txMsb,
  input  logic      nextBit,
  output dpStrobe_t stb,
  output logic      sclDriveLow,
  output logic      sdaDriveLow
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  ctrlState_t state, stateN;
  logic [CNT_W-1:0] bitCnt, cntN;
  logic sdaLow, sdaLowN, sclLow, sclLowN, ackOn, ackOnN, pend, pendN;
  logic fullNow;

  assign fullNow = rxFull && !rxRead;

  always_comb begin
    stateN  = state;
    cntN    = bitCnt;
    sdaLowN = sdaLow;
    sclLowN = sclLow;
    ackOnN  = ackOn;
    pendN   = pend;
    stb     = '0;
    if (stopDet) begin
      stateN          = ST_IDLE;
      sdaLowN         = 1'b0;
      sclLowN         = 1'b0;
      ackOnN          = 1'b0;
      pendN           = 1'b0;
      stb.clrSelected = 1'b1;
      stb.clrBusy     = 1'b1;
      stb.setStop     = 1'b1;
    end else if (startDet) begin
      stateN          = ST_ADDR;
      cntN            = '0;
      sdaLowN         = 1'b0;
      sclLowN         = 1'b0;
      ackOnN          = 1'b0;
      pendN           = 1'b0;
      stb.clrSelected = 1'b1;
      stb.setBusy     = 1'b1;
    end else begin
      unique case (state)
        ST_ADDR: if (sclRise) begin
          stb.shiftIn = 1'b1;
          cntN        = bitCnt + 1'b1;
          if (bitCnt == LAST_BIT) begin
            cntN   = '0;
            ackOnN = 1'b0;
            if (addrMatch) begin
              stb.setSelected = 1'b1;
              stateN          = ST_ADDR_ACK;
            end else begin
              stateN = ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: if (sclFall) begin
          if (!ackOn) begin
            sdaLowN = 1'b1;
            ackOnN  = 1'b1;
          end else begin
            ackOnN = 1'b0;
            cntN   = '0;
            if (readMode) begin
              stb.loadTx = 1'b1;
              sdaLowN    = !txMsb;
              stateN     = ST_TX;
            end else begin
              sdaLowN = 1'b0;
              stateN  = ST_RX;
            end
          end
        end
        ST_RX: if (sclRise) begin
          stb.shiftIn = 1'b1;
          cntN        = bitCnt + 1'b1;
          if (bitCnt == LAST_BIT) begin
            cntN   = '0;
            ackOnN = 1'b0;
            stateN = ST_RX_ACK;
            if (fullNow) begin
              stb.setOverflow = 1'b1;
              pendN           = 1'b1;
            end else begin
              stb.xferNow = 1'b1;
            end
          end
        end
        ST_RX_ACK: if (sclFall) begin
          if (!ackOn) begin
            sdaLowN = 1'b1;
            ackOnN  = 1'b1;
            sclLowN = pend;
          end else begin
            sdaLowN = 1'b0;
            ackOnN  = 1'b0;
            stateN  = ST_RX;
          end
        end
        ST_TX: begin
          if (sclRise) begin
            cntN = bitCnt + 1'b1;
            if (bitCnt == LAST_BIT) begin
              cntN   = '0;
              ackOnN = 1'b0;
              stateN = ST_TX_CHK;
            end
          end else if (sclFall) begin
            stb.shiftOut = 1'b1;
            sdaLowN      = !nextBit;
          end
        end
        ST_TX_CHK: begin
          if (sclFall && !ackOn) begin
            sdaLowN = 1'b0;
          end else if (sclRise && !ackOn) begin
            if (sdaBit) stateN = ST_IGNORE;
            else        ackOnN = 1'b1;
          end else if (sclFall && ackOn) begin
            stb.loadTx = 1'b1;
            sdaLowN    = !txMsb;
            ackOnN     = 1'b0;
            stateN     = ST_TX;
          end
        end
        default: ;
      endcase
      if (pend && rxRead) begin
        stb.xferHeld = 1'b1;
        pendN        = 1'b0;
        sclLowN      = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      sdaLow <= 1'b0;
      sclLow <= 1'b0;
      ackOn  <= 1'b0;
      pend   <= 1'b0;
    end else begin
      state  <= stateN;
      bitCnt <= cntN;
      sdaLow <= sdaLowN;
      sclLow <= sclLowN;
      ackOn  <= ackOnN;
      pend   <= pendN;
    end
  end

  assign sclDriveLow = sclLow;
  assign sdaDriveLow = sdaLow;

  AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE) |-> !sdaDriveLow); // R3
  AST_STRETCH_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    sclDriveLow |-> rxFull); // R6
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    $past(stopDet) |-> (!sdaDriveLow && !sclDriveLow)); // R2

endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
  import i2c_target_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irq
);

  dpStrobe_t stb;
  logic sclRise, sclFall, startDet, stopDet, sdaBit, addrMatch;
  logic rxFull, rxRead, readMode, txMsb, nextBit;

  i2c_target_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ownAddr  (ownAddr),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .stb      (stb),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startDet (startDet),
    .stopDet  (stopDet),
    .sdaBit   (sdaBit),
    .addrMatch(addrMatch),
    .rxFull   (rxFull),
    .rxRead   (rxRead),
    .readMode (readMode),
    .txMsb    (txMsb),
    .nextBit  (nextBit),
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .irq      (irq)
  );

  i2c_target_control #(
    .DATA_W(DATA_W)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sclRise    (sclRise),
    .sclFall    (sclFall),
    .startDet   (startDet),
    .stopDet    (stopDet),
    .sdaBit     (sdaBit),
    .addrMatch  (addrMatch),
    .rxFull     (rxFull),
    .rxRead     (rxRead),
    .readMode   (readMode),
    .txMsb      (txMsb),
    .nextBit    (nextBit),
    .stb        (stb),
    .sclDriveLow(sclDriveLow),
    .sdaDriveLow(sdaDriveLow)
  );

endmodule

// File: tb/test_i2c_target_ctrl.sv
module test_i2c_target_ctrl;

  localparam int HALF = 24;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN = 1'b0;
  logic       sclM = 1'b1, sdaM = 1'b1;
  logic       sclBus, sdaBus;
  logic       sclDriveLow, sdaDriveLow, irq;
  logic [1:0] regAddr = 2'd0;
  logic       regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0] regWrData = 8'h00, regRdData;

  assign sclBus = sclM & ~sclDriveLow;
  assign sdaBus = sdaM & ~sdaDriveLow;

  i2c_target_ctrl i_i2c_target_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ownAddr    (7'h5A),
    .sclIn      (sclBus),
    .sdaIn      (sdaBus),
    .sclDriveLow(sclDriveLow),
    .sdaDriveLow(sdaDriveLow),
    .regAddr    (regAddr),
    .regWrEn    (regWrEn),
    .regRdEn    (regRdEn),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .irq        (irq)
  );

  int vectors = 0;
  int errors  = 0;

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic mStart();
    sdaM = 1'b1; waitClk(HALF);
    sclM = 1'b1; waitClk(HALF);
    sdaM = 1'b0; waitClk(HALF);
    sclM = 1'b0; waitClk(HALF);
  endtask

  task automatic mStop();
    sdaM = 1'b0; waitClk(HALF);
    sclM = 1'b1; waitClk(HALF);
    sdaM = 1'b1; waitClk(HALF);
  endtask

  task automatic bitOut(input logic b, output logic rb);
    sdaM = b; waitClk(HALF);
    sclM = 1'b1;
    do @(negedge clk); while (!sclBus);
    waitClk(HALF / 2);
    rb = sdaBus;
    waitClk(HALF / 2);
    sclM = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic rb;
    for (int i = 7; i >= 0; i--) bitOut(b[i], rb);
    bitOut(1'b1, ack);
  endtask

  task automatic readByte(input logic nak, output logic [7:0] d);
    logic rb;
    for (int i = 7; i >= 0; i--) begin
      bitOut(1'b1, rb);
      d[i] = rb;
    end
    bitOut(nak, rb);
  endtask

  task automatic testReset();
    logic [7:0] d;
    regRead(2'd1, d); check("R1 status", d, 8'h02);
    regRead(2'd2, d); check("R1 enables", d, 8'h00);
    check("R1 irq", irq, 0);
    check("R1 scl drive", sclDriveLow, 0);
    check("R1 sda drive", sdaDriveLow, 0);
  endtask

  task automatic testWriteBytes();
    logic ack;
    logic [7:0] d;
    mStart();
    regRead(2'd1, d); check("R2 busy on start", d[4], 1);
    sendByte(8'hB4, ack); check("R3 address ack", ack, 0);
    regRead(2'd1, d); check("R10 selected on match", d[5], 1);
    sendByte(8'hC3, ack); check("R4 data ack", ack, 0);
    waitClk(4);
    regRead(2'd1, d); check("R4 rx ready", d[0], 1);
    check("R9 rx cause masked", irq, 0);
    regWrite(2'd2, 8'h02); check("R9 rx cause enabled", irq, 1);
    regRead(2'd0, d); check("R4 data MSB first", d, 8'hC3);
    check("R5 irq clears with read", irq, 0);
    regRead(2'd1, d); check("R5 rx ready cleared", d[0], 0);
    sendByte(8'h5E, ack); check("R4 second ack", ack, 0);
    regRead(2'd0, d); check("R4 second byte", d, 8'h5E);
    regWrite(2'd2, 8'h00);
    mStop();
    regRead(2'd1, d);
    check("R2 busy cleared", d[4], 0);
    check("R2 stop seen", d[3], 1);
    check("R10 selected cleared by stop", d[5], 0);
    regWrite(2'd2, 8'h04); check("R9 bus cause enabled", irq, 1);
    regWrite(2'd1, 8'h08);
    regRead(2'd1, d); check("R2 stop flag cleared", d[3], 0);
    check("R9 irq after clear", irq, 0);
    regWrite(2'd2, 8'h00);
  endtask

  task automatic testMismatch();
    logic ack;
    logic [7:0] d;
    mStart();
    sendByte(8'h66, ack); check("R3 mismatch no ack", ack, 1);
    sendByte(8'h77, ack); check("R3 mismatch data ignored", ack, 1);
    regRead(2'd1, d);
    check("R3 no rx ready on mismatch", d[0], 0);
    check("R10 not selected", d[5], 0);
    mStop();
    regWrite(2'd1, 8'h08);
  endtask

  task automatic testStretch();
    logic ack, rb;
    logic [7:0] d;
    mStart();
    sendByte(8'hB4, ack);
    sendByte(8'h11, ack); check("R4 first byte ack", ack, 0);
    for (int i = 7; i >= 0; i--) bitOut(logic'((8'h22 >> i) & 1), rb);
    sdaM = 1'b1; waitClk(HALF);
    sclM = 1'b1; waitClk(60);
    check("R6 scl held low", sclBus, 0);
    regRead(2'd1, d); check("R6 overflow flag", d[2], 1);
    regRead(2'd0, d); check("R6 older byte first", d, 8'h11);
    waitClk(8);
    check("R6 scl released after read", sclBus, 1);
    waitClk(HALF / 2);
    check("R6 held byte acked", sdaBus, 0);
    waitClk(HALF / 2);
    sclM = 1'b0; waitClk(HALF);
    regRead(2'd0, d); check("R6 held byte delivered", d, 8'h22);
    regWrite(2'd1, 8'h04);
    regRead(2'd1, d); check("R6 overflow cleared", d[2], 0);
    mStop();
    regWrite(2'd1, 8'h08);
  endtask

  task automatic testTransmit();
    logic ack, rb;
    logic [7:0] d;
    regWrite(2'd2, 8'h01); check("R9 tx empty enabled", irq, 1);
    regWrite(2'd0, 8'hA5);
    check("R9 irq drops after tx write", irq, 0);
    regRead(2'd1, d); check("R7 tx empty cleared", d[1], 0);
    regWrite(2'd2, 8'h00);
    mStart();
    sendByte(8'hB5, ack); check("R3 read address ack", ack, 0);
    waitClk(4);
    regRead(2'd1, d);
    check("R7 tx empty after load", d[1], 1);
    check("R7 read direction flag", d[6], 1);
    regWrite(2'd0, 8'h3C);
    readByte(1'b0, d); check("R7 first tx byte", d, 8'hA5);
    readByte(1'b1, d); check("R7 second tx byte", d, 8'h3C);
    waitClk(4);
    check("R8 sda released after nak", sdaDriveLow, 0);
    bitOut(1'b1, rb); check("R8 quiet after nak", rb, 1);
    sclM = 1'b0; waitClk(HALF);
    mStop();
    regWrite(2'd1, 8'h08);
  endtask

  task automatic testRepeatedStart();
    logic ack;
    logic [7:0] d;
    mStart();
    sendByte(8'hB4, ack); check("R3 ack before restart", ack, 0);
    regRead(2'd1, d); check("R10 selected before restart", d[5], 1);
    mStart();
    sendByte(8'h66, ack); check("R3 mismatch after restart", ack, 1);
    regRead(2'd1, d);
    check("R10 cleared by repeated start", d[5], 0);
    check("R2 still busy", d[4], 1);
    mStop();
    regRead(2'd1, d); check("R2 idle after stop", d[4], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    testReset();
    testWriteBytes();
    testMismatch();
    testStretch();
    testTransmit();
    testRepeatedStart();
    waitClk(10);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule